// File: doc/BRIEF.md
# Adaptive Deblocking Edge-Line Filter

This block smooths one line of eight 8-bit samples that crosses a block boundary. It has four samples on each side: p0..p3 run away from the edge on one side, and q0..q3 run away from it on the other. The caller supplies the following inputs, all already derived upstream:

- a boundary strength from 0 to 4;
- a luma/chroma select;
- the thresholds alpha and beta;
- the clip limit tc0.

The block first decides whether the step across the edge is a coding artifact or real picture detail. Three gradient tests make that decision. If the step is an artifact, the block applies one of two filters, chosen by the strength:

- a clipped normal filter;
- a strong multi-tap filter.

Luma and chroma behave differently in both filters. The block takes one line per cycle. Each result appears with a valid flag exactly two cycles after its input line.

Sample packing: `p_i[PIX_W-1:0]` is p0, the sample next to the edge. Each further byte holds the next sample outward, up to p3 in the top byte. `q_i` and the outputs use the same packing.

Top module: `dbf_edge_line`

## Requirements
- R1: A strength `bs_i` of 0 returns all eight samples unchanged.
- R2: If any of |p0−q0| < alpha, |p1−p0| < beta or |q1−q0| < beta is false, all eight samples are returned unchanged, whatever the strength.
- R3: Strengths 1 to 3 select the normal filter. It computes d = ((q0−p0)·4 + (p1−q1) + 4) >> 3 with arithmetic shift, clips d to [−tc, tc], and outputs p0+d and q0−d, each saturated to 0..255.
- R4: In the luma normal filter, tc = tc0 plus one for each side whose gradient |x2−x0| < beta. On such a side, x1 gains clip(−tc0, tc0, (x2 + ((p0+q0+1)>>1) − 2·x1) >> 1). On the other side, x1 is unchanged.
- R5: In the chroma normal filter, tc = tc0 + 1, and p1, q1, p2 and q2 are unchanged.
- R6: A strength of 4 or more (values 4..7) on luma selects the strong form on a side when |p0−q0| < (alpha>>2)+2 and that side's |x2−x0| < beta. The strong form gives x0=(x2+2x1+2x0+2y0+y1+4)>>3, x1=(x2+x1+x0+y0+2)>>2 and x2=(2x3+3x2+x1+x0+y0+4)>>3, where y is the opposite side.
- R7: On a luma side with strength 4 whose strong test fails, only x0 changes, to (2x1+x0+y1+2)>>2. x1 and x2 are kept.
- R8: Chroma with strength 4 rewrites only p0 and q0, with the 3-tap form of R7.
- R9: p3 and q3 are never modified. p2 and q2 change only in the strong form of R6.
- R10: `valid_o` is 0 in reset and equals `valid_i` from two clock edges earlier. A line presented on every cycle yields a result on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input line valid |
| bs_i | input | 3 | Boundary strength, 0..4 (5..7 act as 4) |
| chroma_i | input | 1 | 1 = chroma line, 0 = luma line |
| alpha_i | input | PIX_W | Cross-edge threshold |
| beta_i | input | PIX_W | Same-side gradient threshold |
| tc0_i | input | TC_W | Normal filter clip limit |
| p_i | input | 4*PIX_W | p0 (LSB byte)..p3 |
| q_i | input | 4*PIX_W | q0 (LSB byte)..q3 |
| valid_o | output | 1 | Result valid |
| p_o | output | 4*PIX_W | Filtered p0..p3 |
| q_o | output | 4*PIX_W | Filtered q0..q3 |

## Verification
The bench builds the block with its defaults: PIX_W of 8 and TC_W of 5. At these widths alpha spans 0..255, so the strong-filter threshold (alpha>>2)+2 can be driven on both sides of |p0−q0|. tc0 can reach 25, which lets the normal filter's offset push p0 or q0 past 0 and 255 and exercise the saturation. A long back-to-back run of random lines, with samples clustered around a common level, drives every strength through both the accepting and rejecting sides of each gradient test.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_STRONG = 2'd2
  } filt_mode_e;
endpackage

// File: rtl/dbf_gate.sv
module dbf_gate
  import dbf_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [2:0][PIX_W-1:0] p_i,
  input  logic [2:0][PIX_W-1:0] q_i,
  input  logic [PIX_W-1:0]      alpha_i,
  input  logic [PIX_W-1:0]      beta_i,
  input  logic [2:0]            bs_i,
  input  logic                  chroma_i,
  output filt_mode_e            mode_o,
  output logic                  grad_p_o,
  output logic                  grad_q_o,
  output logic                  strong_p_o,
  output logic                  strong_q_o
);
  function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic [PIX_W-1:0] d_pq, d_p10, d_q10, d_p20, d_q20;
  logic [PIX_W:0]   near_thr;
  logic             edge_ok, near;

  assign d_pq  = adiff(p_i[0], q_i[0]);
  assign d_p10 = adiff(p_i[1], p_i[0]);
  assign d_q10 = adiff(q_i[1], q_i[0]);
  assign d_p20 = adiff(p_i[2], p_i[0]);
  assign d_q20 = adiff(q_i[2], q_i[0]);

  assign near_thr = (PIX_W+1)'(alpha_i >> 2) + (PIX_W+1)'(2);
  assign near     = {1'b0, d_pq} < near_thr;
  assign edge_ok  = (d_pq < alpha_i) && (d_p10 < beta_i) && (d_q10 < beta_i);

  assign grad_p_o   = d_p20 < beta_i;
  assign grad_q_o   = d_q20 < beta_i;
  assign strong_p_o = !chroma_i && near && grad_p_o;
  assign strong_q_o = !chroma_i && near && grad_q_o;

  always_comb begin
    if (bs_i == 3'd0 || !edge_ok) mode_o = MODE_PASS;
    else if (bs_i >= 3'd4)        mode_o = MODE_STRONG;
    else                          mode_o = MODE_NORMAL;
  end
endmodule

// File: rtl/dbf_normal.sv
module dbf_normal #(
  parameter int PIX_W = 8,
  parameter int TC_W  = 5
) (
  input  logic [2:0][PIX_W-1:0] p_i,
  input  logic [2:0][PIX_W-1:0] q_i,
  input  logic [TC_W-1:0]       tc0_i,
  input  logic                  chroma_i,
  input  logic                  grad_p_i,
  input  logic                  grad_q_i,
  output logic [1:0][PIX_W-1:0] p_o,
  output logic [1:0][PIX_W-1:0] q_o
);
  localparam int SW = PIX_W + 4;

  function automatic logic signed [SW-1:0] clip3(input logic signed [SW-1:0] lo,
                                                 input logic signed [SW-1:0] hi,
                                                 input logic signed [SW-1:0] v);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  logic signed [SW-1:0] sp0, sp1, sp2, sq0, sq1, sq2;
  logic signed [SW-1:0] tc, tcs, pix_max, raw, delta, avg;
  logic signed [SW-1:0] np0, nq0, tp, tq, np1, nq1;

  assign sp0 = $signed(SW'(p_i[0]));
  assign sp1 = $signed(SW'(p_i[1]));
  assign sp2 = $signed(SW'(p_i[2]));
  assign sq0 = $signed(SW'(q_i[0]));
  assign sq1 = $signed(SW'(q_i[1]));
  assign sq2 = $signed(SW'(q_i[2]));

  assign pix_max = $signed(SW'({PIX_W{1'b1}}));
  assign tcs     = $signed(SW'(tc0_i));
  assign tc      = tcs + $signed(SW'(chroma_i ? 2'd1 : 2'(grad_p_i) + 2'(grad_q_i)));

  assign raw   = ((sq0 - sp0) <<< 2) + (sp1 - sq1) + SW'(4);
  assign delta = clip3(-tc, tc, raw >>> 3);
  assign np0   = clip3('0, pix_max, sp0 + delta);
  assign nq0   = clip3('0, pix_max, sq0 - delta);

  assign avg = (sp0 + sq0 + SW'(1)) >>> 1;
  assign tp  = (sp2 + avg - (sp1 <<< 1)) >>> 1;
  assign tq  = (sq2 + avg - (sq1 <<< 1)) >>> 1;
  assign np1 = sp1 + clip3(-tcs, tcs, tp);
  assign nq1 = sq1 + clip3(-tcs, tcs, tq);

  assign p_o[0] = np0[PIX_W-1:0];
  assign q_o[0] = nq0[PIX_W-1:0];
  assign p_o[1] = (!chroma_i && grad_p_i) ? np1[PIX_W-1:0] : p_i[1];
  assign q_o[1] = (!chroma_i && grad_q_i) ? nq1[PIX_W-1:0] : q_i[1];
endmodule

// File: rtl/dbf_strong_side.sv
module dbf_strong_side #(
  parameter int PIX_W = 8
) (
  input  logic [3:0][PIX_W-1:0] x_i,
  input  logic [PIX_W-1:0]      y0_i,
  input  logic [PIX_W-1:0]      y1_i,
  input  logic                  strong_i,
  output logic [2:0][PIX_W-1:0] n_o
);
  localparam int UW = PIX_W + 4;

  logic [UW-1:0] x0, x1, x2, x3, y0, y1;
  logic [UW-1:0] s0, s1, s2, w0;

  assign x0 = UW'(x_i[0]);
  assign x1 = UW'(x_i[1]);
  assign x2 = UW'(x_i[2]);
  assign x3 = UW'(x_i[3]);
  assign y0 = UW'(y0_i);
  assign y1 = UW'(y1_i);

  assign s0 = x2 + (x1 << 1) + (x0 << 1) + (y0 << 1) + y1 + UW'(4);
  assign s1 = x2 + x1 + x0 + y0 + UW'(2);
  assign s2 = (x3 << 1) + x2 + (x2 << 1) + x1 + x0 + y0 + UW'(4);
  assign w0 = (x1 << 1) + x0 + y1 + UW'(2);

  assign n_o[0] = strong_i ? s0[PIX_W+2:3] : w0[PIX_W+1:2];
  assign n_o[1] = strong_i ? s1[PIX_W+1:2] : x_i[1];
  assign n_o[2] = strong_i ? s2[PIX_W+2:3] : x_i[2];
endmodule

// File: rtl/dbf_edge_line.sv
module dbf_edge_line
  import dbf_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int TC_W  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           bs_i,
  input  logic                 chroma_i,
  input  logic [PIX_W-1:0]     alpha_i,
  input  logic [PIX_W-1:0]     beta_i,
  input  logic [TC_W-1:0]      tc0_i,
  input  logic [4*PIX_W-1:0]   p_i,
  input  logic [4*PIX_W-1:0]   q_i,
  output logic                 valid_o,
  output logic [4*PIX_W-1:0]   p_o,
  output logic [4*PIX_W-1:0]   q_o
);
  localparam int SIDES = 2;

  logic [3:0][PIX_W-1:0] p_in, q_in;
  assign p_in = p_i;
  assign q_in = q_i;

  filt_mode_e mode_d;
  logic       grad_p_d, grad_q_d, strong_p_d, strong_q_d;

  dbf_gate #(.PIX_W(PIX_W)) u_gate (
    .p_i       (p_in[2:0]),
    .q_i       (q_in[2:0]),
    .alpha_i   (alpha_i),
    .beta_i    (beta_i),
    .bs_i      (bs_i),
    .chroma_i  (chroma_i),
    .mode_o    (mode_d),
    .grad_p_o  (grad_p_d),
    .grad_q_o  (grad_q_d),
    .strong_p_o(strong_p_d),
    .strong_q_o(strong_q_d)
  );

  // stage 1: decision plus line
  logic                              s1_valid, s1_chroma;
  filt_mode_e                        s1_mode;
  logic [SIDES-1:0]                  s1_grad, s1_strong;
  logic [TC_W-1:0]                   s1_tc0;
  logic [SIDES-1:0][3:0][PIX_W-1:0]  s1_side;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid  <= 1'b0;
      s1_chroma <= 1'b0;
      s1_mode   <= MODE_PASS;
      s1_grad   <= '0;
      s1_strong <= '0;
      s1_tc0    <= '0;
      s1_side   <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_chroma <= chroma_i;
        s1_mode   <= mode_d;
        s1_grad   <= {grad_q_d, grad_p_d};
        s1_strong <= {strong_q_d, strong_p_d};
        s1_tc0    <= tc0_i;
        s1_side   <= {q_in, p_in};
      end
    end
  end

  // stage 2: filters
  logic [1:0][PIX_W-1:0] nrm_p, nrm_q;
  logic [SIDES-1:0][1:0][PIX_W-1:0] nrm_side;

  dbf_normal #(.PIX_W(PIX_W), .TC_W(TC_W)) u_normal (
    .p_i     (s1_side[0][2:0]),
    .q_i     (s1_side[1][2:0]),
    .tc0_i   (s1_tc0),
    .chroma_i(s1_chroma),
    .grad_p_i(s1_grad[0]),
    .grad_q_i(s1_grad[1]),
    .p_o     (nrm_p),
    .q_o     (nrm_q)
  );
  assign nrm_side[0] = nrm_p;
  assign nrm_side[1] = nrm_q;

  logic [SIDES-1:0][2:0][PIX_W-1:0] str_side;
  logic [SIDES-1:0][3:0][PIX_W-1:0] res_side, out_side;

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    localparam int OPP = SIDES - 1 - g;

    dbf_strong_side #(.PIX_W(PIX_W)) u_strong (
      .x_i     (s1_side[g]),
      .y0_i    (s1_side[OPP][0]),
      .y1_i    (s1_side[OPP][1]),
      .strong_i(s1_strong[g]),
      .n_o     (str_side[g])
    );

    always_comb begin
      res_side[g] = s1_side[g];
      case (s1_mode)
        MODE_NORMAL: res_side[g][1:0] = nrm_side[g];
        MODE_STRONG: res_side[g][2:0] = str_side[g];
        default:     res_side[g]      = s1_side[g];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      out_side <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) out_side <= res_side;
    end
  end

  assign p_o = out_side[0];
  assign q_o = out_side[1];
endmodule

// File: rtl/dbf_edge_line_chk.sv
module dbf_edge_line_chk #(
  parameter int PIX_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [2:0]         bs_i,
  input logic               chroma_i,
  input logic [PIX_W-1:0]   alpha_i,
  input logic [PIX_W-1:0]   beta_i,
  input logic [4*PIX_W-1:0] p_i,
  input logic [4*PIX_W-1:0] q_i,
  input logic               valid_o,
  input logic [4*PIX_W-1:0] p_o,
  input logic [4*PIX_W-1:0] q_o
);
  localparam int W = PIX_W;

  logic [1:0] warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  function automatic logic [W-1:0] adiff(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic gate_fail;
  assign gate_fail = !(adiff(p_i[W-1:0], q_i[W-1:0]) < alpha_i)
                  || !(adiff(p_i[2*W-1:W], p_i[W-1:0]) < beta_i)
                  || !(adiff(q_i[2*W-1:W], q_i[W-1:0]) < beta_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) a_r10_reset_idle: assert (!valid_o);
  end

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm == 2'd2 |-> valid_o == $past(valid_i, 2));

  a_r1_bs0_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && valid_o && $past(valid_i, 2) && $past(bs_i, 2) == 3'd0)
      |-> (p_o == $past(p_i, 2) && q_o == $past(q_i, 2)));

  a_r2_gate_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && valid_o && $past(valid_i, 2) && $past(gate_fail, 2))
      |-> (p_o == $past(p_i, 2) && q_o == $past(q_i, 2)));

  a_r9_outer_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && valid_o && $past(valid_i, 2))
      |-> (p_o[4*W-1:3*W] == $past(p_i[4*W-1:3*W], 2)
        && q_o[4*W-1:3*W] == $past(q_i[4*W-1:3*W], 2)));

  a_r8_chroma_inner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm == 2'd2 && valid_o && $past(valid_i, 2) && $past(chroma_i, 2))
      |-> (p_o[3*W-1:W] == $past(p_i[3*W-1:W], 2)
        && q_o[3*W-1:W] == $past(q_i[3*W-1:W], 2)));
endmodule

bind dbf_edge_line dbf_edge_line_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .bs_i    (bs_i),
  .chroma_i(chroma_i),
  .alpha_i (alpha_i),
  .beta_i  (beta_i),
  .p_i     (p_i),
  .q_i     (q_i),
  .valid_o (valid_o),
  .p_o     (p_o),
  .q_o     (q_o)
);

// File: tb/tb_dbf_edge_line.sv
module tb_dbf_edge_line;
  localparam int PIX_W = 8;
  localparam int TC_W  = 5;
  localparam int W4    = 4 * PIX_W;
  localparam int NSTR  = 300;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            valid_i;
  logic [2:0]      bs_i;
  logic            chroma_i;
  logic [7:0]      alpha_i, beta_i;
  logic [TC_W-1:0] tc0_i;
  logic [W4-1:0]   p_i, q_i;
  logic            valid_o;
  logic [W4-1:0]   p_o, q_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  dbf_edge_line #(.PIX_W(PIX_W), .TC_W(TC_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .bs_i(bs_i),
    .chroma_i(chroma_i), .alpha_i(alpha_i), .beta_i(beta_i), .tc0_i(tc0_i),
    .p_i(p_i), .q_i(q_i), .valid_o(valid_o), .p_o(p_o), .q_o(q_o)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int clipi(int lo, int hi, int v);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // reference from requirements; returns {q, p}
  function automatic logic [2*W4-1:0] model(int bs, bit chroma, int alpha, int beta, int tc0,
                                            logic [W4-1:0] pv, logic [W4-1:0] qv);
    int p[4], q[4], np[4], nq[4];
    int tc, d;
    bit gp, gq, near;
    logic [W4-1:0] po, qo;
    for (int k = 0; k < 4; k++) begin
      p[k] = int'(pv[8*k +: 8]); q[k] = int'(qv[8*k +: 8]);
      np[k] = p[k]; nq[k] = q[k];
    end
    if (bs != 0 && iabs(p[0]-q[0]) < alpha && iabs(p[1]-p[0]) < beta && iabs(q[1]-q[0]) < beta) begin
      gp = iabs(p[2]-p[0]) < beta;
      gq = iabs(q[2]-q[0]) < beta;
      if (bs < 4) begin
        tc = chroma ? tc0 + 1 : tc0 + int'(gp) + int'(gq);
        d = clipi(-tc, tc, ((q[0]-p[0])*4 + (p[1]-q[1]) + 4) >>> 3);
        np[0] = clipi(0, 255, p[0] + d);
        nq[0] = clipi(0, 255, q[0] - d);
        if (!chroma && gp) np[1] = p[1] + clipi(-tc0, tc0, (p[2] + ((p[0]+q[0]+1) >> 1) - 2*p[1]) >>> 1);
        if (!chroma && gq) nq[1] = q[1] + clipi(-tc0, tc0, (q[2] + ((p[0]+q[0]+1) >> 1) - 2*q[1]) >>> 1);
      end else begin
        near = iabs(p[0]-q[0]) < ((alpha >> 2) + 2);
        if (!chroma && near && gp) begin
          np[0] = (p[2] + 2*p[1] + 2*p[0] + 2*q[0] + q[1] + 4) >> 3;
          np[1] = (p[2] + p[1] + p[0] + q[0] + 2) >> 2;
          np[2] = (2*p[3] + 3*p[2] + p[1] + p[0] + q[0] + 4) >> 3;
        end else np[0] = (2*p[1] + p[0] + q[1] + 2) >> 2;
        if (!chroma && near && gq) begin
          nq[0] = (q[2] + 2*q[1] + 2*q[0] + 2*p[0] + p[1] + 4) >> 3;
          nq[1] = (q[2] + q[1] + q[0] + p[0] + 2) >> 2;
          nq[2] = (2*q[3] + 3*q[2] + q[1] + q[0] + p[0] + 4) >> 3;
        end else nq[0] = (2*q[1] + q[0] + p[1] + 2) >> 2;
      end
    end
    for (int k = 0; k < 4; k++) begin
      po[8*k +: 8] = 8'(np[k]); qo[8*k +: 8] = 8'(nq[k]);
    end
    return {qo, po};
  endfunction

  task automatic check(string tag, logic [2*W4-1:0] act, logic [2*W4-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int bs, bit chroma, int alpha, int beta, int tc0,
                       logic [W4-1:0] pv, logic [W4-1:0] qv);
    valid_i = 1'b1; bs_i = 3'(bs); chroma_i = chroma;
    alpha_i = 8'(alpha); beta_i = 8'(beta); tc0_i = TC_W'(tc0);
    p_i = pv; q_i = qv;
  endtask

  // one isolated line: drive, wait two edges, sample, check valid drop
  task automatic run_one(string tag, int bs, bit chroma, int alpha, int beta, int tc0,
                         logic [W4-1:0] pv, logic [W4-1:0] qv, logic [2*W4-1:0] exp);
    @(negedge clk_i);
    drive(bs, chroma, alpha, beta, tc0, pv, qv);
    @(negedge clk_i);
    valid_i = 1'b0;
    @(negedge clk_i);
    check({tag, " R10 valid"}, {63'd0, valid_o}, 64'd1);
    check(tag, {q_o, p_o}, exp);
    check({tag, " vs model"}, exp, model(bs, chroma, alpha, beta, tc0, pv, qv));
    @(negedge clk_i);
    check({tag, " R10 valid drop"}, {63'd0, valid_o}, 64'd0);
  endtask

  task automatic t_reset;
    check("R10 reset valid", {63'd0, valid_o}, 64'd0);
    check("R10 reset data", {q_o, p_o}, 64'd0);
  endtask

  task automatic t_bs0;
    run_one("R1 bs0", 0, 1'b0, 40, 10, 3, 32'h5050_5050, 32'h5858_5858, 64'h5858_5858_5050_5050);
  endtask

  task automatic t_gate;
    run_one("R2 alpha", 2, 1'b0, 8, 10, 3, 32'h5050_5050, 32'h5858_5858, 64'h5858_5858_5050_5050);
    run_one("R2 beta p", 4, 1'b0, 40, 4, 3, 32'h5050_5450, 32'h5858_5858, 64'h5858_5858_5050_5450);
    run_one("R2 beta q", 1, 1'b1, 40, 4, 3, 32'h5050_5050, 32'h5858_5458, 64'h5858_5458_5050_5050);
  endtask

  task automatic t_normal;
    run_one("R3 R4 luma normal", 2, 1'b0, 20, 6, 1, 32'h6464_6464, 32'h6E6E_6E6E, 64'h6E6E_6D6B_6464_6567);
    run_one("R3 R5 clip high", 1, 1'b1, 10, 200, 25, 32'hFFFF_FFFA, 32'h6464_64FF, 64'h6464_64E9_FFFF_FFFF);
    run_one("R3 R5 clip low", 3, 1'b1, 10, 200, 25, 32'h0000_0005, 32'h9B9B_9B00, 64'h9B9B_9B16_0000_0000);
  endtask

  task automatic t_strong;
    run_one("R6 R9 strong", 4, 1'b0, 40, 10, 0, 32'h5050_5050, 32'h5858_5858, 64'h5857_5655_5051_5253);
    run_one("R7 weak", 4, 1'b0, 20, 10, 0, 32'h5050_5050, 32'h5858_5858, 64'h5858_5856_5050_5052);
    run_one("R6 R7 mixed", 4, 1'b0, 40, 10, 0, 32'h5064_5050, 32'h5858_5858,
            model(4, 1'b0, 40, 10, 0, 32'h5064_5050, 32'h5858_5858));
    run_one("R8 chroma", 4, 1'b1, 40, 10, 0, 32'h5050_5050, 32'h5858_5858, 64'h5858_5856_5050_5052);
  endtask

  task automatic t_stream;
    logic [2*W4-1:0] exp_q [NSTR];
    for (int i = 0; i < NSTR + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        check("R10 stream valid", {63'd0, valid_o}, 64'd1);
        check("R1-R9 stream data", {q_o, p_o}, exp_q[i-2]);
      end
      if (i < NSTR) begin
        int base, bs, a, b, t;
        bit ch;
        logic [W4-1:0] pv, qv;
        base = int'($urandom_range(20, 235));
        for (int k = 0; k < 4; k++) begin
          pv[8*k +: 8] = 8'(clipi(0, 255, base + int'($urandom_range(0, 16)) - 8));
          qv[8*k +: 8] = 8'(clipi(0, 255, base + int'($urandom_range(0, 24)) - 12));
        end
        if ($urandom_range(0, 9) == 0) qv[7:0] = 8'($urandom_range(0, 255));
        bs = int'($urandom_range(0, 7));
        ch = 1'($urandom_range(0, 1));
        a  = int'($urandom_range(0, 255));
        b  = int'($urandom_range(0, 20));
        t  = int'($urandom_range(0, 25));
        exp_q[i] = model(bs >= 4 ? 4 : bs, ch, a, b, t, pv, qv);
        drive(bs, ch, a, b, t, pv, qv);
      end else valid_i = 1'b0;
    end
    @(negedge clk_i);
    check("R10 stream idle", {63'd0, valid_o}, 64'd0);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    valid_i = 1'b0; bs_i = '0; chroma_i = 1'b0;
    alpha_i = '0; beta_i = '0; tc0_i = '0; p_i = '0; q_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_bs0();
    t_gate();
    t_normal();
    t_strong();
    t_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule